// File: doc/BRIEF.md
# Four-Channel DAC Serial Command Receiver

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host writes to it over a slow three-wire serial link: a serial clock, a data line and a load strobe. A fourth line, the update strobe, controls when new codes reach the converter. A fast system clock samples all four lines through synchronizers and finds their edges. Nothing in the block runs on the serial clock.

Each command is an 11-bit word. It holds a channel number, a gain flag and an 8-bit code. A falling load strobe stores the word in the addressed channel's staging register. A falling update strobe copies every staging register to the output registers in the same cycle. While the update strobe stays low, the outputs track the staging registers. The outputs drive the converter directly: one 8-bit code and one gain bit per channel.

Top module: `qdac_cmd_rx`

## Requirements
- R1: After reset, every output code is 0, every gain bit is 0 (gain of one), and `frameErr` is 0.
- R2: A data bit is captured on each falling edge of `serClk`. Bits arrive most significant bit first.
- R3: A command is 11 bits long and its layout is fixed:
  - Bits 10:9 select the channel: 00 is channel 0 (A), 01 is channel 1, 10 is channel 2, 11 is channel 3.
  - Bit 8 is the gain flag: 1 means gain of two.
  - Bits 7:0 are the unsigned code.
- R4: A falling edge on `serLoad` after exactly 11 captured bits writes only the addressed channel's staging register. The other channels keep their contents.
- R5: While `serLdac` stays high, `outCode` and `outGain` do not change, even when a staging register is written.
- R6: A falling edge on `serLdac` copies all four staging registers to the outputs together. While `serLdac` stays low, each later write to a staging register appears on the outputs.
- R7: A `serLoad` falling edge after fewer or more than 11 bits does the following:
  - It sets `frameErr`.
  - It writes no staging register, so a later update transfer leaves the outputs as they were.
  - `frameErr` then stays set until reset.
- R8: Every `serLoad` falling edge restarts the bit count. The first well-formed command after a bad one is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Active-low reset |
| serClk | input | 1 | Serial clock; data is taken on its falling edge |
| serData | input | 1 | Serial data, MSB first |
| serLoad | input | 1 | Load strobe; its falling edge commits the command |
| serLdac | input | 1 | Update strobe; low transfers staging to output |
| outCode | output | 32 | Output codes; channel n is in bits [8n+7:8n] |
| outGain | output | 4 | Output gain bits; bit n is channel n, 1 means x2 |
| frameErr | output | 1 | Sticky flag for a load strobe on a wrong bit count |

## Verification
The assertions assume that the serial clock and the load strobe never fall in the same system cycle. They also assume that each input holds its level long enough for the two-stage synchronizer to capture it. The bench meets both assumptions:
- It changes inputs only on falling system-clock edges.
- It holds each serial-clock phase and each strobe level for at least four system cycles.
- It changes data together with the rising serial clock, well before the next falling edge.

The random commands mix good frames with 10-bit and 12-bit frames. They also vary when update pulses occur and when the update strobe is held low.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  // Strobes from the control to the datapath, one cycle wide except xfer
  typedef struct packed {
    logic shift;     // capture one data bit
    logic loadFall;  // load strobe fell (any bit count)
    logic commit;    // load strobe fell on a complete frame
    logic xfer;      // update strobe is low: staging to output
  } qdac_ctl_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter int FRAME_LEN   = 11,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(FRAME_LEN + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  input  logic             serLdac,
  output logic             dataBit,
  output qdac_ctl_t        ctl,
  output logic [CNT_W-1:0] bitCnt,
  output logic             frameErr
);
  // pin order: {ldac, load, data, clk}; strobes idle high, clock idle low
  localparam logic [3:0]       IDLE_PINS = 4'b1100;
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] OVER_CNT  = CNT_W'(FRAME_LEN + 1);

  logic [3:0] pinsIn;
  logic [3:0] syncQ [SYNC_STAGES];
  logic [3:0] pinsS;
  logic [3:0] pinsPrev;
  logic       clkFall;
  logic       loadFall;

  assign pinsIn = {serLdac, serLoad, serData, serClk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= IDLE_PINS;
      pinsPrev <= IDLE_PINS;
    end else begin
      syncQ[0] <= pinsIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      pinsPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinsS    = syncQ[SYNC_STAGES-1];
  assign clkFall  = pinsPrev[0] & ~pinsS[0];
  assign loadFall = pinsPrev[2] & ~pinsS[2];
  assign dataBit  = pinsS[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      frameErr <= 1'b0;
    end else begin
      if (loadFall) begin
        bitCnt <= '0;
        if (bitCnt != FULL_CNT) frameErr <= 1'b1;
      end else if (clkFall && bitCnt != OVER_CNT) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.shift    = clkFall;
    ctl.loadFall = loadFall;
    ctl.commit   = loadFall && (bitCnt == FULL_CNT);
    ctl.xfer     = ~pinsS[3];
  end
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CODE_W   = 8,
  parameter int SEL_W    = $clog2(CHANNELS),
  parameter int FRAME_LEN = SEL_W + 1 + CODE_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dataBit,
  input  qdac_ctl_t                  ctl,
  output logic [CHANNELS*CODE_W-1:0] inCode,
  output logic [CHANNELS-1:0]        inGain,
  output logic [CHANNELS*CODE_W-1:0] outCode,
  output logic [CHANNELS-1:0]        outGain
);
  logic [FRAME_LEN-1:0] shiftReg;
  logic [SEL_W-1:0]     cmdSel;
  logic                 cmdGain;
  logic [CODE_W-1:0]    cmdCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shift) shiftReg <= {shiftReg[FRAME_LEN-2:0], dataBit};
  end

  assign cmdSel  = shiftReg[FRAME_LEN-1 -: SEL_W];
  assign cmdGain = shiftReg[CODE_W];
  assign cmdCode = shiftReg[CODE_W-1:0];

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inCode[ch*CODE_W +: CODE_W]  <= '0;
        inGain[ch]                   <= 1'b0;
        outCode[ch*CODE_W +: CODE_W] <= '0;
        outGain[ch]                  <= 1'b0;
      end else begin
        if (ctl.commit && cmdSel == SEL_W'(ch)) begin
          inCode[ch*CODE_W +: CODE_W] <= cmdCode;
          inGain[ch]                  <= cmdGain;
        end
        if (ctl.xfer) begin
          outCode[ch*CODE_W +: CODE_W] <= inCode[ch*CODE_W +: CODE_W];
          outGain[ch]                  <= inGain[ch];
        end
      end
    end
  end
endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
  import qdac_pkg::*;
#(
  parameter int CHANNELS    = 4,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       serLoad,
  input  logic                       serLdac,
  output logic [CHANNELS*CODE_W-1:0] outCode,
  output logic [CHANNELS-1:0]        outGain,
  output logic                       frameErr
);
  localparam int SEL_W     = $clog2(CHANNELS);
  localparam int FRAME_LEN = SEL_W + 1 + CODE_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);

  qdac_ctl_t                  ctl;
  logic                       dataBit;
  logic [CNT_W-1:0]           bitCnt;
  logic [CHANNELS*CODE_W-1:0] inCode;
  logic [CHANNELS-1:0]        inGain;

  qdac_ctrl #(
    .FRAME_LEN(FRAME_LEN), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .serLdac(serLdac), .dataBit(dataBit),
    .ctl(ctl), .bitCnt(bitCnt), .frameErr(frameErr)
  );

  qdac_datapath #(
    .CHANNELS(CHANNELS), .CODE_W(CODE_W), .SEL_W(SEL_W), .FRAME_LEN(FRAME_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataBit(dataBit), .ctl(ctl),
    .inCode(inCode), .inGain(inGain), .outCode(outCode), .outGain(outGain)
  );
endmodule

// File: rtl/qdac_cmd_rx_checker.sv
module qdac_cmd_rx_checker
  import qdac_pkg::*;
#(
  parameter int CHANNELS  = 4,
  parameter int CODE_W    = 8,
  parameter int FRAME_LEN = 11,
  parameter int CNT_W     = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input qdac_ctl_t                  ctl,
  input logic [CNT_W-1:0]           bitCnt,
  input logic [CHANNELS*CODE_W-1:0] inCode,
  input logic [CHANNELS-1:0]        inGain,
  input logic [CHANNELS*CODE_W-1:0] outCode,
  input logic [CHANNELS-1:0]        outGain,
  input logic                       frameErr
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_LEN + 1);

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= OVER_CNT);

  assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(inCode) && $stable(inGain)));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.xfer |=> ($stable(outCode) && $stable(outGain)));

  assert_out_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.xfer |=> (outCode == $past(inCode) && outGain == $past(inGain)));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadFall && bitCnt != FULL_CNT) |=> frameErr);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);

  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadFall |=> bitCnt == '0);
endmodule

bind qdac_cmd_rx qdac_cmd_rx_checker #(
  .CHANNELS(CHANNELS), .CODE_W(CODE_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rstN(rstN), .ctl(ctl), .bitCnt(bitCnt), .inCode(inCode),
  .inGain(inGain), .outCode(outCode), .outGain(outGain), .frameErr(frameErr)
);

// File: tb/qdac_cmd_rx_bench.sv
`timescale 1ns/1ps
module qdac_cmd_rx_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0, serData = 1'b0, serLoad = 1'b1, serLdac = 1'b1;
  logic [31:0] outCode;
  logic [3:0]  outGain;
  logic        frameErr;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // expected model
  logic [7:0] expInCode [4];
  logic       expInGain [4];
  logic [7:0] expOutCode [4];
  logic       expOutGain [4];
  logic       expErr;
  logic       ldacLow;

  always #10 clk = ~clk;

  qdac_cmd_rx u_qdac_cmd_rx (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .serLdac(serLdac),
    .outCode(outCode), .outGain(outGain), .frameErr(frameErr)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [10:0] mkFrame(input logic [1:0] ch, input logic g,
                                          input logic [7:0] code);
    return {ch, g, code};
  endfunction

  // shift n bits of word, MSB first (R2)
  task automatic sendBits(input int n, input logic [15:0] word);
    for (int i = n - 1; i >= 0; i--) begin
      serData = word[i];
      serClk  = 1'b1;
      waitCyc(4);
      serClk  = 1'b0;
      waitCyc(4);
    end
  endtask

  task automatic pulseLoad(input int nBits, input logic [15:0] word);
    serLoad = 1'b0;
    waitCyc(6);
    serLoad = 1'b1;
    waitCyc(6);
    if (nBits == 11) begin
      expInCode[word[10:9]] = word[7:0];
      expInGain[word[10:9]] = word[8];
      if (ldacLow) begin
        expOutCode[word[10:9]] = word[7:0];
        expOutGain[word[10:9]] = word[8];
      end
    end else begin
      expErr = 1'b1;
    end
  endtask

  task automatic sendCmd(input int nBits, input logic [15:0] word);
    sendBits(nBits, word);
    pulseLoad(nBits, word);
  endtask

  task automatic pulseLdac();
    serLdac = 1'b0;
    waitCyc(6);
    serLdac = 1'b1;
    waitCyc(6);
    for (int c = 0; c < 4; c++) begin
      expOutCode[c] = expInCode[c];
      expOutGain[c] = expInGain[c];
    end
  endtask

  task automatic checkAll(input string req);
    bit bad = 1'b0;
    checks++;
    for (int c = 0; c < 4; c++) begin
      if (outCode[c*8 +: 8] !== expOutCode[c] || outGain[c] !== expOutGain[c]) begin
        $display("FAIL %s ch%0d code %0h gain %0b expected code %0h gain %0b",
                 req, c, outCode[c*8 +: 8], outGain[c], expOutCode[c], expOutGain[c]);
        bad = 1'b1;
      end
    end
    if (frameErr !== expErr) begin
      $display("FAIL %s frameErr %0b expected %0b", req, frameErr, expErr);
      bad = 1'b1;
    end
    if (bad) errors++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused;
    logic [10:0] w;
    unused = $urandom(32'd1234);
    for (int c = 0; c < 4; c++) begin
      expInCode[c] = '0; expInGain[c] = 1'b0;
      expOutCode[c] = '0; expOutGain[c] = 1'b0;
    end
    expErr = 1'b0;
    ldacLow = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(5);
    checkAll("R1 reset");

    // R3 layout: channel 0, gain x2, code A5; outputs held while LDAC high (R5)
    sendCmd(11, 16'(mkFrame(2'b00, 1'b1, 8'hA5)));
    checkAll("R5 hold before update");
    pulseLdac();
    checkAll("R3 R6 channel 0 transfer");

    // R4: each channel separately, all transferred together (R6)
    sendCmd(11, 16'(mkFrame(2'b01, 1'b0, 8'h3C)));
    sendCmd(11, 16'(mkFrame(2'b10, 1'b1, 8'hFF)));
    sendCmd(11, 16'(mkFrame(2'b11, 1'b0, 8'h01)));
    checkAll("R5 hold after three writes");
    pulseLdac();
    checkAll("R4 R6 all channels");

    // R2 MSB first: asymmetric code
    sendCmd(11, 16'(mkFrame(2'b10, 1'b0, 8'h80)));
    pulseLdac();
    checkAll("R2 msb first");

    // R7 short frame: no write, error set
    sendCmd(10, 16'h3FF);
    pulseLdac();
    checkAll("R7 short frame");

    // R8 recovery after bad frame
    sendCmd(11, 16'(mkFrame(2'b11, 1'b1, 8'h5A)));
    pulseLdac();
    checkAll("R8 recovery");

    // R7 long frame: last 11 bits form a valid-looking word, still ignored
    sendCmd(12, {5'b0, 11'(mkFrame(2'b01, 1'b1, 8'h77))});
    pulseLdac();
    checkAll("R7 long frame");

    // R6 outputs follow while LDAC held low
    serLdac = 1'b0;
    ldacLow = 1'b1;
    waitCyc(6);
    sendCmd(11, 16'(mkFrame(2'b01, 1'b1, 8'hC3)));
    checkAll("R6 follow while low");
    sendCmd(11, 16'(mkFrame(2'b00, 1'b0, 8'h00)));
    checkAll("R6 follow second write");
    serLdac = 1'b1;
    ldacLow = 1'b0;
    waitCyc(6);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int kind;
      w = 11'($urandom);
      kind = int'($urandom % 8);
      if (kind == 0) sendCmd(10, 16'(w));
      else if (kind == 1) sendCmd(12, 16'($urandom));
      else sendCmd(11, 16'(w));
      checkAll("R5 random hold");
      if ($urandom % 2 == 0) begin
        pulseLdac();
        checkAll("R4 R6 random transfer");
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule